// File: doc/BRIEF.md
# Power-Management Fixed Register Block

This block is a small bus slave that sits on a platform's power-management register space. It gives four byte-wide registers that software uses to control platform power: a deep-idle register, a system reset register, a sleep control register and a sleep status register. Each register acts through the kind of access made to it. Reading the deep-idle register asks the clock control logic for the C3 idle state. Writing a programmed magic byte to the reset register asks for a full-system reset. Writing a sleep type together with an enable bit to the sleep control register starts sleep entry.

A wake-event input ends a pending sleep and sets a wake flag. Software polls that flag in the status register and clears it by writing a 1 to it. The bus has an address, separate read and write strobes, an access-size code and byte data. Read data comes back one cycle after the read strobe. The registers sit at `BASE_ADDR` + 0 (deep idle), + 1 (reset), + 2 (sleep control) and + 3 (sleep status). Addresses outside that window are ignored.

Top module: `pm_fixed_regs`

## Requirements
- R1: After reset, `c3_req`, `sys_rst_req`, `sleep_req`, `sleep_type` and `bus_rdata` are all zero, and all four registers read back 00h.
- R2: Only byte accesses (`bus_size` = 2'b00) take effect. Any other size code, or an address outside the four-register window, causes no side effect, changes no state, and returns 00h.
- R3: The deep-idle register reads as 00h and ignores writes. Each byte read of it raises `c3_req` for exactly one cycle, in the same cycle that its read data is presented.
- R4: A byte write of exactly `RST_VALUE` to the reset register raises `sys_rst_req` for one cycle, in the cycle after the write strobe.
- R5: A write of any other byte to the reset register has no effect. The reset register always reads as 00h.
- R6: A sleep control write with bit 5 set latches bits 4:2 as the sleep type. In the following cycle it asserts `sleep_req`, with `sleep_type` equal to that type. The register reads back the latched type in bits 4:2, and 0 in every other bit, bit 5 included.
- R7: A sleep control write with bit 5 clear only updates the stored type. While `sleep_req` is high, sleep control writes are ignored, and `sleep_req` and `sleep_type` hold until a wake event.
- R8: `wake_evt` drops `sleep_req` in the next cycle. A sleep control write in the same cycle as `wake_evt` is ignored.
- R9: The wake flag is bit 7 of the status register, and the other bits read as 0. `wake_evt` sets the flag in the next cycle. A status write with bit 7 set clears it, and a write with bit 7 clear does not. A wake event in the same cycle as a clearing write leaves the flag set.
- R10: `bus_rdata` carries the read value in the cycle after a read strobe. In any cycle that does not follow a read strobe, it is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_size | input | 2 | Access size code, 2'b00 = byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, one cycle after the read strobe |
| wake_evt | input | 1 | Synchronous wake event |
| c3_req | output | 1 | One-cycle request to enter C3 |
| sys_rst_req | output | 1 | One-cycle full-system reset request |
| sleep_req | output | 1 | Sleep entry request, held until wake |
| sleep_type | output | SLP_TYPE_W | Latched sleep type while sleeping |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that `wake_evt` is synchronous to `clk`. The directed tasks drive each strobe for a single cycle, keep the two strobes exclusive, and raise `wake_evt` on its own or together with one chosen write, so both collision orderings that the requirements define are reached. The clearing-versus-setting case of the wake flag and the start-versus-wake case of sleep entry are the only deliberate overlaps.

// File: rtl/pm_regs_pkg.sv
package pm_regs_pkg;
   localparam int unsigned PM_DATA_W   = 8;
   localparam int unsigned PM_NUM_REGS = 4;

   // register slots relative to the block base address
   localparam int unsigned IDX_IDLE3  = 0;
   localparam int unsigned IDX_RESET  = 1;
   localparam int unsigned IDX_SLPCTL = 2;
   localparam int unsigned IDX_SLPSTS = 3;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_QUAD = 2'd3
   } acc_size_e;
endpackage

// File: rtl/pm_access_decode.sv
module pm_access_decode
   import pm_regs_pkg::*;
#(
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned BASE_ADDR = 8,
   parameter int unsigned NREG      = PM_NUM_REGS
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [1:0]        size,
   output logic [NREG-1:0]   rd_hit,
   output logic [NREG-1:0]   wr_hit
);
   localparam int unsigned SPAN = 1 << ADDR_W;

   if (BASE_ADDR + NREG > SPAN) begin : g_bad_window
      $error("register window does not fit the address width");
   end

   logic byte_ok;
   assign byte_ok = (size == SZ_BYTE);

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + i);
      logic match;
      assign match     = byte_ok && (addr == SLOT_ADDR);
      assign rd_hit[i] = rd && match;
      assign wr_hit[i] = wr && match;
   end
endmodule

// File: rtl/pm_pulse_unit.sv
module pm_pulse_unit
   import pm_regs_pkg::*;
#(
   parameter logic [PM_DATA_W-1:0] RST_VALUE = 8'h06
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 idle_rd,
   input  logic                 rst_wr,
   input  logic [PM_DATA_W-1:0] wdata,
   output logic                 c3_req,
   output logic                 sys_rst_req
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c3_req      <= 1'b0;
         sys_rst_req <= 1'b0;
      end else begin
         c3_req      <= idle_rd;
         sys_rst_req <= rst_wr && (wdata == RST_VALUE);
      end
   end

   AST_C3_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      c3_req |-> $past(idle_rd)); // R3
   AST_RST_FROM_MAGIC: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_req |-> ($past(rst_wr) && $past(wdata) == RST_VALUE)); // R4
   AST_RST_WRONG_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_wr && wdata != RST_VALUE) |=> !sys_rst_req); // R5
endmodule

// File: rtl/pm_sleep_unit.sv
module pm_sleep_unit
   import pm_regs_pkg::*;
#(
   parameter int unsigned TYPE_W   = 3,
   parameter int unsigned TYPE_LSB = 2,
   parameter int unsigned EN_BIT   = 5,
   parameter int unsigned STS_BIT  = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_wr,
   input  logic                 sts_wr,
   input  logic [PM_DATA_W-1:0] wdata,
   input  logic                 wake_evt,
   output logic                 sleep_req,
   output logic [TYPE_W-1:0]    sleep_type,
   output logic [PM_DATA_W-1:0] ctl_view,
   output logic [PM_DATA_W-1:0] sts_view
);
   localparam int unsigned TYPE_MSB = TYPE_LSB + TYPE_W - 1;

   if (TYPE_MSB >= EN_BIT || EN_BIT >= PM_DATA_W || STS_BIT >= PM_DATA_W) begin : g_bad_layout
      $error("sleep field layout does not fit one byte");
   end

   logic [TYPE_W-1:0] type_q;
   logic              wake_q;
   logic              ctl_take;

   assign ctl_take = ctl_wr && !sleep_req && !wake_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q    <= '0;
         sleep_req <= 1'b0;
      end else if (wake_evt) begin
         sleep_req <= 1'b0;
      end else if (ctl_take) begin
         type_q <= wdata[TYPE_LSB +: TYPE_W];
         if (wdata[EN_BIT]) sleep_req <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                       wake_q <= 1'b0;
      else if (wake_evt)                wake_q <= 1'b1;
      else if (sts_wr && wdata[STS_BIT]) wake_q <= 1'b0;
   end

   assign sleep_type = sleep_req ? type_q : '0;

   always_comb begin
      ctl_view = '0;
      ctl_view[TYPE_LSB +: TYPE_W] = type_q;
      sts_view = '0;
      sts_view[STS_BIT] = wake_q;
   end

   AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req && !wake_evt) |=> (sleep_req && $stable(sleep_type))); // R7
   AST_SLEEP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> !sleep_req); // R8
   AST_WAKE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wake_evt |=> sts_view[STS_BIT]); // R9
   AST_WAKE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && wdata[STS_BIT] && !wake_evt) |=> !sts_view[STS_BIT]); // R9
   AST_SLEEP_START: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && wdata[EN_BIT] && !sleep_req && !wake_evt) |=>
         (sleep_req && sleep_type == $past(wdata[TYPE_LSB +: TYPE_W]))); // R6
endmodule

// File: rtl/pm_fixed_regs.sv
module pm_fixed_regs
   import pm_regs_pkg::*;
#(
   parameter int unsigned          ADDR_W     = 4,
   parameter int unsigned          BASE_ADDR  = 8,
   parameter logic [7:0]           RST_VALUE  = 8'h06,
   parameter int unsigned          SLP_TYPE_W = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     bus_addr,
   input  logic                  bus_rd,
   input  logic                  bus_wr,
   input  logic [1:0]            bus_size,
   input  logic [7:0]            bus_wdata,
   output logic [7:0]            bus_rdata,
   input  logic                  wake_evt,
   output logic                  c3_req,
   output logic                  sys_rst_req,
   output logic                  sleep_req,
   output logic [SLP_TYPE_W-1:0] sleep_type
);
   localparam int unsigned TYPE_LSB = 2;
   localparam int unsigned EN_BIT   = 5;
   localparam int unsigned STS_BIT  = 7;

   logic [PM_NUM_REGS-1:0] rd_hit;
   logic [PM_NUM_REGS-1:0] wr_hit;
   logic [PM_DATA_W-1:0]   ctl_view;
   logic [PM_DATA_W-1:0]   sts_view;
   logic [PM_DATA_W-1:0]   rd_next;

   pm_access_decode #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .NREG      (PM_NUM_REGS)
   ) u_decode (
      .addr   (bus_addr),
      .rd     (bus_rd),
      .wr     (bus_wr),
      .size   (bus_size),
      .rd_hit (rd_hit),
      .wr_hit (wr_hit)
   );

   pm_pulse_unit #(
      .RST_VALUE (RST_VALUE)
   ) u_pulse (
      .clk         (clk),
      .rst_n       (rst_n),
      .idle_rd     (rd_hit[IDX_IDLE3]),
      .rst_wr      (wr_hit[IDX_RESET]),
      .wdata       (bus_wdata),
      .c3_req      (c3_req),
      .sys_rst_req (sys_rst_req)
   );

   pm_sleep_unit #(
      .TYPE_W   (SLP_TYPE_W),
      .TYPE_LSB (TYPE_LSB),
      .EN_BIT   (EN_BIT),
      .STS_BIT  (STS_BIT)
   ) u_sleep (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctl_wr     (wr_hit[IDX_SLPCTL]),
      .sts_wr     (wr_hit[IDX_SLPSTS]),
      .wdata      (bus_wdata),
      .wake_evt   (wake_evt),
      .sleep_req  (sleep_req),
      .sleep_type (sleep_type),
      .ctl_view   (ctl_view),
      .sts_view   (sts_view)
   );

   // deep-idle and reset slots always return zero
   always_comb begin
      rd_next = '0;
      if (rd_hit[IDX_SLPCTL]) rd_next = ctl_view;
      if (rd_hit[IDX_SLPSTS]) rd_next = sts_view;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bus_rdata <= '0;
      else        bus_rdata <= rd_next;
   end

   AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> (bus_rdata == 8'h00)); // R10
   AST_SIZE_NO_C3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size != 2'b00) |=> !c3_req); // R2
   AST_SIZE_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_size != 2'b00) |=> !sys_rst_req); // R2
   AST_C3_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      c3_req |-> (bus_rdata == 8'h00)); // R3
endmodule

// File: tb/test_pm_fixed_regs.sv
module test_pm_fixed_regs;
   localparam int unsigned AW   = 4;
   localparam logic [3:0]  A_IDLE = 4'h8;
   localparam logic [3:0]  A_RST  = 4'h9;
   localparam logic [3:0]  A_CTL  = 4'hA;
   localparam logic [3:0]  A_STS  = 4'hB;
   localparam logic [7:0]  MAGIC  = 8'h06;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_size = 2'b00;
   logic [7:0]    bus_wdata = '0;
   logic [7:0]    bus_rdata;
   logic          wake_evt = 1'b0;
   logic          c3_req;
   logic          sys_rst_req;
   logic          sleep_req;
   logic [2:0]    sleep_type;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   pm_fixed_regs #(
      .ADDR_W (AW), .BASE_ADDR (8), .RST_VALUE (MAGIC), .SLP_TYPE_W (3)
   ) i_pm_fixed_regs (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_rd (bus_rd),
      .bus_wr (bus_wr), .bus_size (bus_size), .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata), .wake_evt (wake_evt), .c3_req (c3_req),
      .sys_rst_req (sys_rst_req), .sleep_req (sleep_req), .sleep_type (sleep_type)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // one-cycle strobes driven at negedge, results sampled at the following negedge
   task automatic rd(input logic [3:0] a, input logic [1:0] sz);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0; bus_size = 2'b00;
   endtask

   task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [7:0] d, input logic wk);
      @(negedge clk);
      bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1'b1; wake_evt = wk;
      @(negedge clk);
      bus_wr = 1'b0; bus_size = 2'b00; wake_evt = 1'b0;
   endtask

   task automatic wake();
      @(negedge clk);
      wake_evt = 1'b1;
      @(negedge clk);
      wake_evt = 1'b0;
   endtask

   task automatic t_reset();
      check("R1", "c3 after reset", c3_req, 0);
      check("R1", "rst after reset", sys_rst_req, 0);
      check("R1", "sleep after reset", sleep_req, 0);
      check("R1", "type after reset", sleep_type, 0);
      check("R1", "rdata after reset", bus_rdata, 0);
      for (int k = 0; k < 4; k++) begin
         rd(A_IDLE + 4'(k), 2'b00);
         check("R1", "register reads 00h", bus_rdata, 0);
      end
   endtask

   task automatic t_idle3();
      rd(A_IDLE, 2'b00);
      check("R3", "c3 pulse with data", c3_req, 1);
      check("R3", "idle reads 00h", bus_rdata, 0);
      @(negedge clk);
      check("R3", "c3 one cycle", c3_req, 0);
      check("R10", "rdata zero in idle cycle", bus_rdata, 0);
      wr(A_IDLE, 2'b00, 8'hFF, 1'b0);
      check("R3", "write gives no c3", c3_req, 0);
      rd(A_CTL, 2'b00);
      check("R3", "idle write left ctl", bus_rdata, 0);
   endtask

   task automatic t_size();
      rd(A_IDLE, 2'b10);
      check("R2", "wide read no c3", c3_req, 0);
      wr(A_RST, 2'b01, MAGIC, 1'b0);
      check("R2", "half write no reset", sys_rst_req, 0);
      wr(A_CTL, 2'b11, 8'h3C, 1'b0);
      check("R2", "wide ctl write no sleep", sleep_req, 0);
      rd(A_CTL, 2'b00);
      check("R2", "wide ctl write no state", bus_rdata, 0);
      rd(A_CTL, 2'b01);
      check("R2", "half read returns 00h", bus_rdata, 0);
      wr(4'h1, 2'b00, MAGIC, 1'b0);
      check("R2", "unmapped write no reset", sys_rst_req, 0);
      rd(4'h0, 2'b00);
      check("R2", "unmapped read no c3", c3_req, 0);
   endtask

   task automatic t_reset_reg();
      wr(A_RST, 2'b00, 8'h05, 1'b0);
      check("R5", "wrong byte no reset", sys_rst_req, 0);
      rd(A_RST, 2'b00);
      check("R5", "reset reg reads 00h", bus_rdata, 0);
      wr(A_RST, 2'b00, MAGIC, 1'b0);
      check("R4", "magic write resets", sys_rst_req, 1);
      @(negedge clk);
      check("R4", "reset one cycle", sys_rst_req, 0);
   endtask

   task automatic t_sleep();
      wr(A_CTL, 2'b00, 8'h14, 1'b0);
      check("R7", "type-only write no sleep", sleep_req, 0);
      rd(A_CTL, 2'b00);
      check("R7", "type stored", bus_rdata, 8'h14);
      wr(A_CTL, 2'b00, 8'h2C, 1'b0);
      check("R6", "enable starts sleep", sleep_req, 1);
      check("R6", "sleep type out", sleep_type, 3);
      rd(A_CTL, 2'b00);
      check("R6", "enable reads 0", bus_rdata, 8'h0C);
      wr(A_CTL, 2'b00, 8'h3C, 1'b0);
      check("R7", "write ignored while asleep", sleep_type, 3);
      rd(A_CTL, 2'b00);
      check("R7", "stored type unchanged", bus_rdata, 8'h0C);
      check("R7", "sleep held", sleep_req, 1);
      wake();
      check("R8", "wake ends sleep", sleep_req, 0);
      rd(A_STS, 2'b00);
      check("R9", "wake flag set", bus_rdata, 8'h80);
      wr(A_STS, 2'b00, 8'h7F, 1'b0);
      rd(A_STS, 2'b00);
      check("R9", "bit7 clear write keeps flag", bus_rdata, 8'h80);
      wr(A_STS, 2'b00, 8'h80, 1'b0);
      rd(A_STS, 2'b00);
      check("R9", "write 1 clears flag", bus_rdata, 8'h00);
   endtask

   task automatic t_collide();
      wr(A_STS, 2'b00, 8'h80, 1'b1);
      rd(A_STS, 2'b00);
      check("R9", "set beats clear", bus_rdata, 8'h80);
      wr(A_CTL, 2'b00, 8'h38, 1'b1);
      check("R8", "start with wake ignored", sleep_req, 0);
      rd(A_CTL, 2'b00);
      check("R8", "type not taken with wake", bus_rdata, 8'h0C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle3();
      t_size();
      t_reset_reg();
      t_sleep();
      t_collide();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule